// File: doc/BRIEF.md
# Job Ring Occupancy and Interrupt Controller

This block keeps count for one command-queue ring pair: an input ring that software fills with jobs and an output ring that holds result entries until software retires them. Software does not push or pop single entries. It writes batch counts: how many jobs it has just placed in the input ring, and how many results it has just consumed from the output ring. The hardware turns those counts into the free room left in the input ring and the number of full slots in the output ring. It also owns the input read index and the output write index.

A simple handshake stands in for the job consumer (`job_avail` / `job_take`) and another for the result producer (`res_valid` / `res_ready`). Each accepted result can raise a completion interrupt. A batch count that would overrun a ring is refused and reported as a typed error in the interrupt status word. When stop-on-error is configured, an error halts job dispatch. Halt progress is reported until software resets the ring.

Top module: `jrc_ring_ctrl`

## Requirements
- R1: A write to address 0 sets the ring size from the low 10 bits of the data; higher bits are ignored. Both rings use this size. After reset the size is 0, so the input room and all counts read 0.
- R2: A write of N to address 1 with N no larger than the input room adds N pending jobs and lowers `in_room` by N. `job_avail` is high when jobs are pending and the ring is not halted. Each accepted `job_take` raises `in_room` by one.
- R3: A write to address 1 with N larger than the input room leaves every count unchanged. It sets status bit 1 (error) and, if no error is already held, error type 9 in status bits 11..8.
- R4: `in_rd_idx` advances by one per accepted job and `out_wr_idx` by one per accepted result. Each index returns to 0 when it reaches the ring size.
- R5: A write of N to address 2 lowers `out_full` by N when N is no larger than `out_full`. Otherwise the counts are unchanged and the write reports error type 8 in the same way as R3.
- R6: A result is accepted only when `res_valid` is high and `res_ready` is high, and `res_ready` is high exactly when `out_full` is below the ring size. Each accepted result raises `out_full` by one. A refused result changes nothing.
- R7: Status bit 0 (ring interrupt) sets on each accepted result. When coalescing is enabled (config bit 1), it sets only if the full count after the write is at least COAL_LEVEL (default 4). Writing address 3 with data bit 0 set clears status bit 0. Writing address 3 with data bit 1 set clears the error flag and the error type. The first error type is held until it is cleared.
- R8: Writing address 5 with data bit 0 set, while no taken job is awaiting its result, clears the pending jobs, the full count, both indices and the halt state. Status bits 0 and 1 are kept. If a taken job is still outstanding, the command is ignored and reports error type 7.
- R9: `irq` is high when status bit 0 or bit 1 is set and config bit 0 (mask) is clear. Config is written at address 4.
- R10: With config bit 2 (stop-on-error) set, any error halts the ring and holds `job_avail` low. Status bits 3..2 read 01 (value 0x4) while taken jobs are outstanding and 10 (value 0x8) once none are. The halt lasts until an accepted ring reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 size, 1 jobs added, 2 results removed, 3 status clear, 4 config, 5 command) |
| reg_wdata | input | DATA_W | Register write data |
| job_avail | output | 1 | A pending job may be taken |
| job_take | input | 1 | Consumer takes one job |
| res_valid | input | 1 | Producer offers one result |
| res_ready | output | 1 | Output ring has a free slot |
| in_room | output | SIZE_W | Free entries in the input ring |
| in_rd_idx | output | SIZE_W | Input ring read index |
| out_full | output | SIZE_W | Occupied entries in the output ring |
| out_wr_idx | output | SIZE_W | Output ring write index |
| int_status | output | DATA_W | Interrupt status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the batch counts right up to the room limit and one past it. A design that compared with the wrong bound would either accept a job count that overruns the ring or refuse the last legal slot, and the room values would drift. Both indices are walked across the wrap point. Results are offered to a full output ring, where a design that ignored `res_ready` would push the full count above the ring size. The halt is driven with a job still outstanding, so a reset in that state must be refused with type 7 and the halt field must step from 0x4 to 0x8 once the last result returns. Coalescing and masking are checked for an interrupt raised too early or one that leaks through the mask.

// File: rtl/jrc_pkg.sv
// Shared definitions for the job ring occupancy controller.
// Assumes: register addresses are 3 bits wide; error and halt codes are
// placed into the status word by jrc_status.
package jrc_pkg;

    typedef enum logic [2:0] {
        RA_SIZE  = 3'd0,
        RA_ADD   = 3'd1,
        RA_REM   = 3'd2,
        RA_STAT  = 3'd3,
        RA_CFG   = 3'd4,
        RA_CMD   = 3'd5
    } reg_addr_e;

    typedef enum logic [3:0] {
        ET_NONE    = 4'd0,
        ET_RESET   = 4'd7,
        ET_REM_OVF = 4'd8,
        ET_ADD_OVF = 4'd9
    } err_type_e;

    typedef enum logic [1:0] {
        HS_RUN  = 2'b00,
        HS_BUSY = 2'b01,
        HS_DONE = 2'b10
    } halt_e;

    typedef struct packed {
        logic soe;
        logic coal;
        logic mask;
    } cfg_t;

endpackage

// File: rtl/jrc_level.sv
// Occupancy counter with batch add/subtract and single-step up/down.
// Assumes: the caller only enables a batch change that keeps the level in
// range; clear has priority over every other change.
module jrc_level #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bat_add,
    input  logic         bat_sub,
    input  logic [W-1:0] bat_n,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] level
);

    logic [W-1:0] add_v;
    logic [W-1:0] sub_v;
    logic [W-1:0] up_v;
    logic [W-1:0] dn_v;

    // Select the contributions of this cycle.
    always_comb begin
        add_v = bat_add ? bat_n : '0;
        sub_v = bat_sub ? bat_n : '0;
        up_v  = {{(W-1){1'b0}}, step_up};
        dn_v  = {{(W-1){1'b0}}, step_dn};
    end

    // Hold the level, clearing on reset or ring clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level <= '0;
        end else begin
            level <= level + add_v - sub_v + up_v - dn_v;
        end
    end

endmodule

// File: rtl/jrc_wrap_idx.sv
// Ring index that steps by one and returns to zero at the ring size.
// Assumes: limit is the current ring size; a limit of zero or one keeps
// the index at zero.
module jrc_wrap_idx #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] idx
);

    logic [W:0] inc;

    // Candidate next index one wider than the index itself.
    always_comb begin
        inc = {1'b0, idx} + {{W{1'b0}}, 1'b1};
    end

    // Advance with wrap; clear on reset or ring clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (adv) begin
            if (inc >= {1'b0, limit}) begin
                idx <= '0;
            end else begin
                idx <= inc[W-1:0];
            end
        end
    end

endmodule

// File: rtl/jrc_status.sv
// Configuration, interrupt status word, error capture and halt tracking.
// Assumes: at most one error source fires per cycle (each comes from a
// different register address); the first error type is held until the
// error flag is cleared by software.
module jrc_status #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              stat_wr,
    input  logic [2:0]        ctl_bits,
    input  logic              err_add,
    input  logic              err_rem,
    input  logic              err_rst,
    input  logic              int_set,
    input  logic              idle,
    input  logic              ring_clr,
    output jrc_pkg::cfg_t     cfg_q,
    output logic              halted,
    output logic [DATA_W-1:0] int_status,
    output logic              irq
);
    import jrc_pkg::*;

    localparam int PAD_W = DATA_W - 12;

    logic      int_flag;
    logic      err_flag;
    err_type_e err_type;
    err_type_e new_type;
    logic      any_err;
    halt_e     halt_st;

    // Pick the error code raised this cycle.
    always_comb begin
        any_err  = err_add || err_rem || err_rst;
        new_type = err_add ? ET_ADD_OVF :
                   err_rem ? ET_REM_OVF :
                   err_rst ? ET_RESET   : ET_NONE;
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= cfg_t'(ctl_bits);
        end
    end

    // Ring interrupt flag: set by a result, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_flag <= 1'b0;
        end else if (int_set) begin
            int_flag <= 1'b1;
        end else if (stat_wr && ctl_bits[0]) begin
            int_flag <= 1'b0;
        end
    end

    // Error flag and type: first error is held until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_type <= ET_NONE;
        end else if (any_err) begin
            if (!err_flag) begin
                err_flag <= 1'b1;
                err_type <= new_type;
            end
        end else if (stat_wr && ctl_bits[1]) begin
            err_flag <= 1'b0;
            err_type <= ET_NONE;
        end
    end

    // Halt state: entered on an error under stop-on-error, left on ring clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (any_err && cfg_q.soe) begin
            halted <= 1'b1;
        end else if (ring_clr) begin
            halted <= 1'b0;
        end
    end

    // Halt progress reported from outstanding work.
    always_comb begin
        if (!halted) begin
            halt_st = HS_RUN;
        end else if (idle) begin
            halt_st = HS_DONE;
        end else begin
            halt_st = HS_BUSY;
        end
    end

    // Assemble the status word and the interrupt request.
    always_comb begin
        int_status = {{PAD_W{1'b0}}, err_type, 4'b0000, halt_st, err_flag, int_flag};
        irq        = (int_flag || err_flag) && !cfg_q.mask;
    end

endmodule

// File: rtl/jrc_ring_ctrl.sv
// Job ring occupancy and interrupt controller (top).
// Decodes register writes, validates batch counts against ring room,
// tracks pending jobs, full result slots, jobs in flight, both ring
// indices, and feeds the status block.
// Assumes: one register write per cycle; batch counts are compared with
// the full data width so large values are refused, never truncated.
module jrc_ring_ctrl #(
    parameter int SIZE_W     = 10,
    parameter int DATA_W     = 32,
    parameter int COAL_LEVEL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              job_avail,
    input  logic              job_take,
    input  logic              res_valid,
    output logic              res_ready,
    output logic [SIZE_W-1:0] in_room,
    output logic [SIZE_W-1:0] in_rd_idx,
    output logic [SIZE_W-1:0] out_full,
    output logic [SIZE_W-1:0] out_wr_idx,
    output logic [DATA_W-1:0] int_status,
    output logic              irq
);
    import jrc_pkg::*;

    localparam int FL_W  = SIZE_W + 1;
    localparam int EXT_W = DATA_W - SIZE_W;

    logic [SIZE_W-1:0] ring_size;
    logic [SIZE_W-1:0] pend_q;
    logic [FL_W-1:0]   inflight;
    logic [SIZE_W-1:0] bat_n;
    logic              wr_add, wr_rem, wr_cmd;
    logic              add_bad, rem_bad, rst_bad;
    logic              add_ok, rem_ok, ring_clr;
    logic              take, res_wr, coal_hit, int_set, idle;
    logic              halted;
    cfg_t              cfg_q;

    // Ring size register: low bits of the data only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_size <= '0;
        end else if (reg_wr && reg_addr == RA_SIZE) begin
            ring_size <= reg_wdata[SIZE_W-1:0];
        end
    end

    // Derived room, handshakes and write decoding.
    always_comb begin
        in_room   = (pend_q >= ring_size) ? '0 : ring_size - pend_q;
        wr_add    = reg_wr && reg_addr == RA_ADD;
        wr_rem    = reg_wr && reg_addr == RA_REM;
        wr_cmd    = reg_wr && reg_addr == RA_CMD && reg_wdata[0];
        add_bad   = wr_add && (reg_wdata > {{EXT_W{1'b0}}, in_room});
        rem_bad   = wr_rem && (reg_wdata > {{EXT_W{1'b0}}, out_full});
        idle      = (inflight == '0);
        rst_bad   = wr_cmd && !idle;
        add_ok    = wr_add && !add_bad;
        rem_ok    = wr_rem && !rem_bad;
        ring_clr  = wr_cmd && idle;
        bat_n     = reg_wdata[SIZE_W-1:0];
        job_avail = (pend_q != '0) && !halted;
        take      = job_take && job_avail;
        res_ready = out_full < ring_size;
        res_wr    = res_valid && res_ready;
        coal_hit  = ({1'b0, out_full} + {{SIZE_W{1'b0}}, 1'b1}) >= FL_W'(COAL_LEVEL);
        int_set   = res_wr && (!cfg_q.coal || coal_hit);
    end

    jrc_level #(.W(SIZE_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ring_clr),
        .bat_add (add_ok),
        .bat_sub (1'b0),
        .bat_n   (bat_n),
        .step_up (1'b0),
        .step_dn (take),
        .level   (pend_q)
    );

    jrc_level #(.W(SIZE_W)) u_full (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ring_clr),
        .bat_add (1'b0),
        .bat_sub (rem_ok),
        .bat_n   (bat_n),
        .step_up (res_wr),
        .step_dn (1'b0),
        .level   (out_full)
    );

    jrc_level #(.W(FL_W)) u_flight (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ring_clr),
        .bat_add (1'b0),
        .bat_sub (1'b0),
        .bat_n   ('0),
        .step_up (take),
        .step_dn (res_wr && !idle),
        .level   (inflight)
    );

    jrc_wrap_idx #(.W(SIZE_W)) u_rd_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ring_clr),
        .adv   (take),
        .limit (ring_size),
        .idx   (in_rd_idx)
    );

    jrc_wrap_idx #(.W(SIZE_W)) u_wr_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ring_clr),
        .adv   (res_wr),
        .limit (ring_size),
        .idx   (out_wr_idx)
    );

    jrc_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (reg_wr && reg_addr == RA_CFG),
        .stat_wr    (reg_wr && reg_addr == RA_STAT),
        .ctl_bits   (reg_wdata[2:0]),
        .err_add    (add_bad),
        .err_rem    (rem_bad),
        .err_rst    (rst_bad),
        .int_set    (int_set),
        .idle       (idle),
        .ring_clr   (ring_clr),
        .cfg_q      (cfg_q),
        .halted     (halted),
        .int_status (int_status),
        .irq        (irq)
    );

endmodule

// File: rtl/jrc_ring_ctrl_chk.sv
// Property checker for jrc_ring_ctrl, attached by bind below.
module jrc_ring_ctrl_chk #(
    parameter int SIZE_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              job_avail,
    input logic              job_take,
    input logic              res_valid,
    input logic [SIZE_W-1:0] in_room,
    input logic [SIZE_W-1:0] in_rd_idx,
    input logic [SIZE_W-1:0] out_full,
    input logic [SIZE_W-1:0] out_wr_idx,
    input logic [DATA_W-1:0] int_status,
    input logic              irq,
    input logic [SIZE_W:0]   inflight
);
    localparam int EXT_W = DATA_W - SIZE_W;

    AST_ADD_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && reg_wdata > {{EXT_W{1'b0}}, in_room} && !job_take)
        |=> (in_room == $past(in_room) && int_status[1])); // R3

    AST_REM_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2 && reg_wdata > {{EXT_W{1'b0}}, out_full} && !res_valid)
        |=> (out_full == $past(out_full) && int_status[1])); // R5

    AST_TAKE_FREES_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (job_take && job_avail && !reg_wr && in_room != '0)
        |=> (in_room == $past(in_room) + 1'b1)); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd5 && reg_wdata[0] && inflight == '0)
        |=> (in_rd_idx == '0 && out_wr_idx == '0 && out_full == '0)); // R8

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4 && reg_wdata[0]) |=> !irq); // R9

    AST_HALT_NO_JOBS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[3:2] != 2'b00) |-> !job_avail); // R10

    AST_HALT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(int_status[3:2])); // R10

endmodule

bind jrc_ring_ctrl jrc_ring_ctrl_chk #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .job_avail  (job_avail),
    .job_take   (job_take),
    .res_valid  (res_valid),
    .in_room    (in_room),
    .in_rd_idx  (in_rd_idx),
    .out_full   (out_full),
    .out_wr_idx (out_wr_idx),
    .int_status (int_status),
    .irq        (irq),
    .inflight   (inflight)
);

// File: tb/jrc_ring_ctrl_test.sv
// Scoreboard bench: driver tasks update a reference model and queue the
// expected port view; a monitor pops and compares on falling edges.
module jrc_ring_ctrl_test;

    localparam int SIZE_W = 10;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              job_avail;
    logic              job_take = 1'b0;
    logic              res_valid = 1'b0;
    logic              res_ready;
    logic [SIZE_W-1:0] in_room;
    logic [SIZE_W-1:0] in_rd_idx;
    logic [SIZE_W-1:0] out_full;
    logic [SIZE_W-1:0] out_wr_idx;
    logic [DATA_W-1:0] int_status;
    logic              irq;

    jrc_ring_ctrl #(.SIZE_W(SIZE_W), .DATA_W(DATA_W), .COAL_LEVEL(4)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .job_avail(job_avail), .job_take(job_take),
        .res_valid(res_valid), .res_ready(res_ready), .in_room(in_room),
        .in_rd_idx(in_rd_idx), .out_full(out_full), .out_wr_idx(out_wr_idx),
        .int_status(int_status), .irq(irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        string tag;
        int    room, full, ridx, widx, stat, irq, avail, ready;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state.
    int m_size = 0, m_pend = 0, m_full = 0, m_ridx = 0, m_widx = 0, m_infl = 0;
    int m_int = 0, m_err = 0, m_type = 0, m_halt = 0;
    int m_mask = 0, m_coal = 0, m_soe = 0;

    function automatic int m_room();
        return (m_pend >= m_size) ? 0 : m_size - m_pend;
    endfunction

    task automatic raise(input int t);
        if (m_err == 0) begin
            m_err = 1;
            m_type = t;
        end
        if (m_soe != 0) m_halt = 1;
    endtask

    task automatic push(input string tag);
        exp_t e;
        int hb;
        hb = (m_halt == 0) ? 0 : ((m_infl == 0) ? 2 : 1);
        e.tag   = tag;
        e.room  = m_room();
        e.full  = m_full;
        e.ridx  = m_ridx;
        e.widx  = m_widx;
        e.stat  = (m_type << 8) | (hb << 2) | (m_err << 1) | m_int;
        e.irq   = ((m_int | m_err) != 0 && m_mask == 0) ? 1 : 0;
        e.avail = (m_pend > 0 && m_halt == 0) ? 1 : 0;
        e.ready = (m_full < m_size) ? 1 : 0;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic reg_write(input int a, input int d, input string tag);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = DATA_W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            0: m_size = d & 32'h3FF;
            1: if (d > m_room()) raise(9); else m_pend += d;
            2: if (d > m_full) raise(8); else m_full -= d;
            3: begin
                if (d[0]) m_int = 0;
                if (d[1]) begin m_err = 0; m_type = 0; end
            end
            4: begin m_mask = d[0]; m_coal = d[1]; m_soe = d[2]; end
            5: if (d[0]) begin
                if (m_infl != 0) raise(7);
                else begin
                    m_pend = 0; m_full = 0; m_ridx = 0; m_widx = 0; m_halt = 0;
                end
            end
            default: ;
        endcase
        push(tag);
    endtask

    task automatic take_job(input string tag);
        @(negedge clk);
        job_take = 1'b1;
        @(negedge clk);
        job_take = 1'b0;
        if (m_pend > 0 && m_halt == 0) begin
            m_pend--;
            m_infl++;
            m_ridx = (m_ridx + 1 >= m_size) ? 0 : m_ridx + 1;
        end
        push(tag);
    endtask

    task automatic put_result(input string tag);
        @(negedge clk);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        if (m_full < m_size) begin
            if (m_coal == 0 || m_full + 1 >= 4) m_int = 1;
            m_full++;
            m_widx = (m_widx + 1 >= m_size) ? 0 : m_widx + 1;
            if (m_infl > 0) m_infl--;
        end
        push(tag);
    endtask

    // Monitor: pop one expectation per falling edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (int'(in_room) != e.room || int'(out_full) != e.full ||
                    int'(in_rd_idx) != e.ridx || int'(out_wr_idx) != e.widx ||
                    int'(int_status) != e.stat || int'(irq) != e.irq ||
                    int'(job_avail) != e.avail || int'(res_ready) != e.ready) begin
                    n_bad++;
                    $display("FAIL %s: got room=%0d full=%0d ridx=%0d widx=%0d stat=%h irq=%0d avail=%0d ready=%0d exp room=%0d full=%0d ridx=%0d widx=%0d stat=%h irq=%0d avail=%0d ready=%0d",
                        e.tag, in_room, out_full, in_rd_idx, out_wr_idx, int_status, irq,
                        job_avail, res_ready, e.room, e.full, e.ridx, e.widx, e.stat,
                        e.irq, e.avail, e.ready);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push("R1 reset state");
        reg_write(0, 32'hFFFF_FC04, "R1 size low bits");
        reg_write(1, 3, "R2 add within room");
        reg_write(1, 2, "R3 add overflow");
        reg_write(3, 2, "R7 clear error");
        for (int i = 0; i < 3; i++) take_job("R2 R4 take job");
        for (int i = 0; i < 3; i++) put_result("R6 R7 result");
        reg_write(1, 4, "R2 fill to zero room");
        take_job("R4 read index wrap");
        put_result("R4 R6 write index wrap full");
        put_result("R6 result refused when full");
        reg_write(2, 5, "R5 remove overflow");
        reg_write(2, 4, "R5 remove all");
        reg_write(4, 1, "R9 mask");
        reg_write(3, 3, "R7 clear both");
        reg_write(4, 0, "R9 unmask");
        reg_write(5, 1, "R8 ring reset idle");
        reg_write(4, 2, "R7 coalescing on");
        reg_write(1, 4, "R7 coal add");
        for (int i = 0; i < 4; i++) take_job("R7 coal take");
        for (int i = 0; i < 3; i++) put_result("R7 coal below level");
        put_result("R7 coal reaches level");
        reg_write(2, 4, "R5 drain");
        reg_write(3, 1, "R7 clear int");
        reg_write(4, 4, "R10 stop on error");
        reg_write(1, 2, "R10 add two");
        take_job("R10 take one");
        reg_write(1, 10, "R10 R3 overflow halts");
        reg_write(3, 2, "R10 clear error keeps halt");
        reg_write(5, 1, "R8 reset refused type 7");
        put_result("R10 halt complete");
        reg_write(5, 1, "R8 R10 reset leaves halt");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule